// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a peripheral timer that runs in one of two modes. As a watchdog, it emits a one-cycle system reset pulse when its count reaches the selected period. As an interval timer, it sets a sticky interrupt flag at each period instead.

An 8-bit control register protects the configuration. A bus write to it is accepted only when the upper byte of the write data carries the unlock key 0x5A. A write with any other key is dropped and also raises the reset pulse. The count advances on one of two clock-enable inputs, fast or auxiliary. It can be frozen, or forced back to zero.

The same register decides how the external reset pin is treated. In reset mode, a low level on the pin is passed on as a reset request. In interrupt mode, a selected edge on the pin produces a one-cycle non-maskable interrupt request, gated by an interrupt-enable input. Clock generation, the interrupt controller and the processor sit outside the block. The chip's reset network feeds `rst_n`.

Top module: `wdt_ivt`

## Requirements
- R1: A write with `bus_sel`=0 loads the control register from `bus_wdata[7:0]` only when `bus_wdata[15:8]` equals 0x5A. The field layout of `ctrl_o` is: bit7 hold, bit6 edge select, bit5 pin function, bit4 mode, bit3 count clear, bit2 clock select, bits1:0 period select.
- R2: A control write with any other key leaves `ctrl_o` unchanged. It drives `wdt_rst_o` high for exactly the one cycle after the write.
- R3: An accepted write with bit3 set makes `count_o` 0 after the write. Bit3 always reads back as 0 in `ctrl_o`.
- R4: While bit7 (hold) is 1, `count_o` does not change.
- R5: Bit2 = 0 advances the count on `tick_fast`. Bit2 = 1 advances it on `tick_aux`. The other enable has no effect.
- R6: Bits1:0 select the period N: 00 → 32768, 01 → 8192, 10 → 512, 11 → 64. Starting from count 0, expiry happens on the N-th advancing tick, and the count returns to 0 at that tick.
- R7: In watchdog mode (bit4 = 0), an expiry drives `wdt_rst_o` high for one cycle and leaves `ivl_flag_o` untouched.
- R8: In interval mode (bit4 = 1), an expiry sets `ivl_flag_o` and does not pulse `wdt_rst_o`. The flag stays set until a write with `bus_sel`=1 and `bus_wdata[0]`=1 clears it. A flag write with bit0 = 0 has no effect.
- R9: With bit5 = 0, `pin_rst_o` follows the inverted `ext_pin` one cycle later. With bit5 = 1, `pin_rst_o` stays 0.
- R10: With bit5 = 1 and `nmi_ie` high, `nmi_o` pulses for one cycle, one cycle after a rising edge of `ext_pin` (bit6 = 0) or a falling edge (bit6 = 1).
- R11: Toggling bit6 while the pin is steady can itself raise `nmi_o` if `nmi_ie` is high. While `nmi_ie` is low, `nmi_o` never rises.
- R12: After reset, `ctrl_o`=0x00, `count_o`=0, and all outputs are low. The timer then runs as a watchdog on `tick_fast` with period 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects control register, 1 selects flag register |
| bus_wdata | input | 16 | Write data (key in upper byte for control writes) |
| tick_fast | input | 1 | Fast count enable |
| tick_aux | input | 1 | Auxiliary count enable |
| ext_pin | input | 1 | External reset / NMI pin, idle high |
| nmi_ie | input | 1 | Enable for the pin interrupt request |
| ctrl_o | output | 8 | Control register contents |
| count_o | output | 16 | Current count |
| ivl_flag_o | output | 1 | Interval expiry flag |
| wdt_rst_o | output | 1 | System reset pulse (expiry or key violation) |
| pin_rst_o | output | 1 | Reset request from the pin |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
A corrupted control register shows up at `ctrl_o` on the very next sample. It also shifts the expiry instant, so a wrong period or tap is caught on the exact cycle of the expected reset pulse or flag. A count that slips by one tick moves that edge by one cycle and is reported at the boundary sample, one tick before and at N. A stale pin history shows as a spurious or missing `nmi_o` pulse one cycle after the pin or edge-select change.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the keyed watchdog / interval timer.
// Assumes the control byte layout listed in the brief (bit positions fixed).
package wdt_pkg;

    typedef struct packed {
        logic       hold;       // bit7: freeze count
        logic       edge_fall;  // bit6: 1 = falling edge NMI
        logic       nmi_mode;   // bit5: 1 = pin acts as NMI
        logic       ivl_mode;   // bit4: 1 = interval timer
        logic       clr;        // bit3: count clear (never stored as 1)
        logic       aux_sel;    // bit2: 1 = auxiliary enable
        logic [1:0] ivl_sel;    // bits1:0: period select
    } wdt_ctrl_t;

    // Count bit whose rise marks expiry for a given period select.
    function automatic int tap_bit(input int w, input int s);
        case (s)
            0:       return w - 1;
            1:       return w - 3;
            2:       return w - 7;
            default: return w - 10;
        endcase
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
// Keyed control register. Loads the low byte only when the upper byte
// matches KEY; flags a key violation otherwise. Assumes single-cycle writes.
module wdt_ctrl_reg #(
    parameter logic [7:0] KEY = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wdata,
    output wdt_pkg::wdt_ctrl_t ctrl_q,
    output logic              clr_pulse,
    output logic              key_bad
);
    import wdt_pkg::*;

    logic key_ok;
    wdt_ctrl_t nxt;

    // Decode key match and the self-clearing clear request.
    always_comb begin
        key_ok    = (wdata[15:8] == KEY);
        key_bad   = wr_en && !key_ok;
        clr_pulse = wr_en && key_ok && wdata[3];
        nxt       = wdt_ctrl_t'(wdata[7:0]);
        nxt.clr   = 1'b0;
    end

    // Hold the control byte; load on keyed writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && key_ok)
            ctrl_q <= nxt;
    end

    a_r2_bad_key_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        key_bad |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt_counter.sv
// Free-running count with selectable enable, hold, clear and tap-based
// expiry. The count restarts at zero on expiry so each period is exact.
// Assumes CNT_W >= 10 so every tap exists.
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_aux,
    input  logic             aux_sel,
    input  logic             hold,
    input  logic             clr,
    input  logic [1:0]       ivl_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam int NSEL = 4;

    logic             adv;
    logic [CNT_W-1:0] nxt;
    logic [NSEL-1:0]  rise;

    // Pick the enable and form the incremented count.
    always_comb begin
        adv = (aux_sel ? tick_aux : tick_fast) && !hold;
        nxt = cnt_q + 1'b1;
    end

    // One rising-edge detector per selectable tap.
    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int TB = wdt_pkg::tap_bit(CNT_W, g);
        assign rise[g] = nxt[TB] && !cnt_q[TB];
    end

    assign expire = adv && rise[ivl_sel] && !clr;

    // Count register: clear beats expiry, expiry beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || expire)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= nxt;
    end

    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(cnt_q));
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_pin.sv
// External pin handling: level reset request or edge-selected NMI.
// The edge select is folded into the sampled level, so flipping it can
// itself look like an edge. Assumes ext_pin is already synchronous.
module wdt_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic nmi_mode,
    input  logic edge_fall,
    input  logic nmi_ie,
    output logic pin_rst_o,
    output logic nmi_o
);
    logic lvl;
    logic lvl_q;

    assign lvl = ext_pin ^ edge_fall;

    // Track the folded level and register both pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q     <= 1'b1;
            pin_rst_o <= 1'b0;
            nmi_o     <= 1'b0;
        end else begin
            lvl_q     <= lvl;
            pin_rst_o <= !nmi_mode && !ext_pin;
            nmi_o     <= nmi_mode && nmi_ie && lvl && !lvl_q;
        end
    end

    a_r9_no_rst_in_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_mode |=> !pin_rst_o);
    a_r10_nmi_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_mode |=> !nmi_o);
    a_r11_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_ie |=> !nmi_o);

endmodule

// File: rtl/wdt_ivt.sv
// Top of the keyed watchdog / interval timer. Joins the control register,
// counter and pin logic, and owns the interval flag and reset pulse.
// Assumes one bus write per cycle and synchronous clock enables.
module wdt_ivt #(
    parameter int         CNT_W = 16,
    parameter logic [7:0] KEY   = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_sel,
    input  logic [15:0]      bus_wdata,
    input  logic             tick_fast,
    input  logic             tick_aux,
    input  logic             ext_pin,
    input  logic             nmi_ie,
    output logic [7:0]       ctrl_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ivl_flag_o,
    output logic             wdt_rst_o,
    output logic             pin_rst_o,
    output logic             nmi_o
);
    import wdt_pkg::*;

    wdt_ctrl_t ctrl;
    logic      clr_pulse;
    logic      key_bad;
    logic      expire;
    logic      flag_clr;

    wdt_ctrl_reg #(.KEY(KEY)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && !bus_sel),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl),
        .clr_pulse(clr_pulse),
        .key_bad  (key_bad)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_fast(tick_fast),
        .tick_aux (tick_aux),
        .aux_sel  (ctrl.aux_sel),
        .hold     (ctrl.hold),
        .clr      (clr_pulse),
        .ivl_sel  (ctrl.ivl_sel),
        .cnt_q    (count_o),
        .expire   (expire)
    );

    wdt_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .nmi_mode (ctrl.nmi_mode),
        .edge_fall(ctrl.edge_fall),
        .nmi_ie   (nmi_ie),
        .pin_rst_o(pin_rst_o),
        .nmi_o    (nmi_o)
    );

    assign ctrl_o   = ctrl;
    assign flag_clr = bus_we && bus_sel && bus_wdata[0];

    // Reset pulse on watchdog expiry or key violation; sticky interval flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst_o  <= 1'b0;
            ivl_flag_o <= 1'b0;
        end else begin
            wdt_rst_o <= key_bad || (expire && !ctrl.ivl_mode);
            if (expire && ctrl.ivl_mode)
                ivl_flag_o <= 1'b1;
            else if (flag_clr)
                ivl_flag_o <= 1'b0;
        end
    end

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (count_o == '0));
    a_r7_ivl_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.ivl_mode && !key_bad) |=> !wdt_rst_o);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_flag_o && !flag_clr) |=> ivl_flag_o);
    a_r12_ctrl_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[3]);

endmodule

// File: tb/wdt_ivt_tb_top.sv
// Self-checking bench: a vector table of control writes, then directed
// tests for periods, modes, pin handling and the reset default.
module wdt_ivt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        tick_fast = 1'b1;
    logic        tick_aux = 1'b0;
    logic        ext_pin = 1'b1;
    logic        nmi_ie = 1'b0;
    logic [7:0]  ctrl_o;
    logic [15:0] count_o;
    logic        ivl_flag_o, wdt_rst_o, pin_rst_o, nmi_o;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wdt_ivt dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .tick_fast(tick_fast), .tick_aux(tick_aux),
        .ext_pin(ext_pin), .nmi_ie(nmi_ie), .ctrl_o(ctrl_o), .count_o(count_o),
        .ivl_flag_o(ivl_flag_o), .wdt_rst_o(wdt_rst_o), .pin_rst_o(pin_rst_o),
        .nmi_o(nmi_o)
    );

    // {write data, expected ctrl_o, expected wdt_rst_o}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {16'h5A80, 8'h80, 8'h00},
        {16'h5A97, 8'h97, 8'h00},
        {16'h1234, 8'h97, 8'h01},
        {16'h5A8C, 8'h84, 8'h00},
        {16'hA5FF, 8'h84, 8'h01},
        {16'h5AE3, 8'hE3, 8'h00},
        {16'h5A80, 8'h80, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cyc(3);
        // R12 reset state
        chk("R12 ctrl", ctrl_o, 8'h00);
        chk("R12 count", count_o, 16'h0);
        chk("R12 outs", {ivl_flag_o, wdt_rst_o, pin_rst_o, nmi_o}, 4'b0);
        rst_n = 1'b1;

        // R1 R2 R3 vector walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VEC[i][31:16]);
            chk("R1 ctrl", ctrl_o, VEC[i][15:8]);
            chk("R2 rst", wdt_rst_o, VEC[i][0]);
            cyc(1);
            chk("R2 one-cycle", wdt_rst_o, 1'b0);
        end

        // R3 R4 clear then hold
        wr(1'b0, 16'h5A88);
        chk("R3 cleared", count_o, 16'h0);
        chk("R3 reads 0", ctrl_o, 8'h80);
        cyc(10);
        chk("R4 held", count_o, 16'h0);

        // R6 R7 watchdog /64
        wr(1'b0, 16'h5A0B);
        cyc(63);
        chk("R6 count 63", count_o, 16'd63);
        chk("R7 no rst early", wdt_rst_o, 1'b0);
        cyc(1);
        chk("R7 rst at 64", wdt_rst_o, 1'b1);
        chk("R7 flag untouched", ivl_flag_o, 1'b0);
        chk("R6 restart", count_o, 16'h0);
        cyc(1);
        chk("R7 pulse ends", wdt_rst_o, 1'b0);

        // R8 interval /64
        wr(1'b0, 16'h5A1B);
        cyc(63);
        chk("R8 flag early", ivl_flag_o, 1'b0);
        cyc(1);
        chk("R8 flag set", ivl_flag_o, 1'b1);
        chk("R8 no rst", wdt_rst_o, 1'b0);
        wr(1'b0, 16'h5A9B);
        cyc(3);
        chk("R8 sticky", ivl_flag_o, 1'b1);
        wr(1'b1, 16'h0000);
        chk("R8 write 0 ignored", ivl_flag_o, 1'b1);
        wr(1'b1, 16'h0001);
        chk("R8 w1c", ivl_flag_o, 1'b0);

        // R6 interval /512
        wr(1'b0, 16'h5A1A);
        cyc(511);
        chk("R6 count 511", count_o, 16'd511);
        chk("R6 no flag 511", ivl_flag_o, 1'b0);
        cyc(1);
        chk("R6 flag at 512", ivl_flag_o, 1'b1);
        wr(1'b0, 16'h5A9A);
        wr(1'b1, 16'h0001);

        // R5 auxiliary enable
        wr(1'b0, 16'h5A1F);
        cyc(20);
        chk("R5 fast ignored", count_o, 16'h0);
        tick_aux = 1'b1;
        cyc(5);
        tick_aux = 1'b0;
        chk("R5 aux counts", count_o, 16'd5);
        wr(1'b0, 16'h5A9F);

        // R9 pin reset mode
        ext_pin = 1'b0;
        cyc(1);
        chk("R9 pin rst", pin_rst_o, 1'b1);
        ext_pin = 1'b1;
        cyc(1);
        chk("R9 pin released", pin_rst_o, 1'b0);

        // R10 rising edge NMI
        nmi_ie = 1'b1;
        wr(1'b0, 16'h5AA0);
        ext_pin = 1'b0;
        cyc(1);
        chk("R10 no nmi on fall", nmi_o, 1'b0);
        chk("R9 no rst in nmi mode", pin_rst_o, 1'b0);
        ext_pin = 1'b1;
        cyc(1);
        chk("R10 nmi on rise", nmi_o, 1'b1);
        cyc(1);
        chk("R10 nmi one cycle", nmi_o, 1'b0);

        // R10 falling edge NMI
        wr(1'b0, 16'h5AE0);
        chk("R10 no nmi on sel change", nmi_o, 1'b0);
        cyc(1);
        chk("R10 still none", nmi_o, 1'b0);
        ext_pin = 1'b0;
        cyc(1);
        chk("R10 nmi on fall", nmi_o, 1'b1);

        // R11 edge-select toggle with pin low
        nmi_ie = 1'b0;
        wr(1'b0, 16'h5AA0);
        wr(1'b0, 16'h5AE0);
        chk("R11 masked a", nmi_o, 1'b0);
        cyc(1);
        chk("R11 masked b", nmi_o, 1'b0);
        nmi_ie = 1'b1;
        wr(1'b0, 16'h5AA0);
        wr(1'b0, 16'h5AE0);
        chk("R11 toggle none yet", nmi_o, 1'b0);
        cyc(1);
        chk("R11 toggle nmi", nmi_o, 1'b1);

        // R12 default watchdog /32768 on fast enable
        nmi_ie = 1'b0;
        ext_pin = 1'b1;
        rst_n = 1'b0;
        cyc(3);
        chk("R12 ctrl after reset", ctrl_o, 8'h00);
        chk("R12 flag after reset", ivl_flag_o, 1'b0);
        rst_n = 1'b1;
        cyc(32767);
        chk("R12 count", count_o, 16'd32767);
        chk("R12 no rst early", wdt_rst_o, 1'b0);
        cyc(1);
        chk("R12 default expiry", wdt_rst_o, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule